// File: doc/BRIEF.md
# Exception Entry Sequencer

This block sits beside a processor's control unit and decides, whenever a one-cycle strobe marks a decision point, whether the core should enter a synchronous exception, enter an external interrupt, or neither. When an event is taken, it performs the whole entry update in one clock edge. It saves the old status word, the return PC and the stack pointer. It sets the block, privileged and bank bits, records the event code and loads the handler address.

Synchronous exceptions always win over interrupts. An exception that arrives while the status word's block bit is set cannot be handled normally. Instead the block raises a one-cycle reset request and leaves every other output untouched; one exempt code is still allowed through. Interrupts are refused while a delay slot is in progress, while the block bit is set (unless the core is asleep), and whenever their level does not exceed the current mask. Without a strobe, every output holds its value.

Top module: `exc_entry_seq`

## Requirements
- R1: When an exception and an interrupt are both pending at a strobe, the exception is taken: the exception-event output takes its code and the interrupt-event output is unchanged.
- R2: At a strobe with the block bit (status bit 28) set and an exception pending whose code is not 0x1E0, the reset-request output is 1 for exactly the following cycle. No other output changes.
- R3: An exception with code 0x1E0 is taken normally even with the block bit set.
- R4: With the block bit set and only an interrupt pending, the interrupt is refused unless the sleep input is 1. Taking any event drives the sleep output to 0.
- R5: An interrupt is taken only if its 4-bit level is strictly greater than the mask in status bits 7:4. When taken, the interrupt-event output receives its vector and the PC output becomes VBR + 0x600.
- R6: On entry, the saved-status output gets the incoming status, the saved-PC output gets the PC, and the saved-stack output gets R15. The new status is the incoming status with bits 28 (block), 29 (bank) and 30 (privileged) set.
- R7: An event taken while the delay-slot input is 1 saves PC − 2 and drives the delay-slot output to 0.
- R8: Exception codes 0x000, 0x020 and 0x140 also clear status bit 15, set bits 7:4 to 0xF, and load PC 0xA0000000.
- R9: Codes 0x040 and 0x060 load VBR + 0x400. Every other exception code loads VBR + 0x100.
- R10: The trap code 0x160 adds 2 to the saved PC, on top of any delay-slot adjustment.
- R11: No interrupt is taken while the delay-slot input is 1.
- R12: Synchronous reset sets the status output to 0x700000F0 and every other output to 0.
- R13: In a cycle without the strobe, or at a strobe that takes nothing, all state outputs hold their values. In the no-event case, the sleep and delay-slot outputs copy their inputs, and the reset request is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| take_i | input | 1 | One-cycle decision strobe |
| exc_valid_i | input | 1 | Synchronous exception pending |
| exc_code_i | input | 12 | Exception event code |
| irq_pend_i | input | 1 | External interrupt pending |
| irq_vec_i | input | 12 | Interrupt vector code |
| irq_level_i | input | 4 | Interrupt priority level |
| sr_i | input | 32 | Current status word |
| pc_i | input | 32 | Current PC |
| r15_i | input | 32 | Current stack pointer |
| vbr_i | input | 32 | Vector base |
| sleep_i | input | 1 | Core is sleeping |
| dslot_i | input | 1 | Core is in a delay slot |
| sr_o | output | 32 | Updated status word |
| ssr_o | output | 32 | Saved status |
| spc_o | output | 32 | Saved return PC |
| sgr_o | output | 32 | Saved stack pointer |
| expevt_o | output | 12 | Last exception code |
| intevt_o | output | 12 | Last interrupt vector |
| pc_o | output | 32 | Handler PC |
| rst_req_o | output | 1 | Reset request pulse |
| sleep_o | output | 1 | Updated sleep flag |
| dslot_o | output | 1 | Updated delay-slot flag |

## Verification
The hardest situations to reach are the ones where several refusal conditions overlap, because each one masks the next at the ports. Examples are an interrupt arriving with the block bit set while the core is asleep, or a trap raised from a delay slot, where the two saved-PC adjustments cancel. Directed strobes build each combination explicitly, with the block bit, sleep, delay-slot, level and mask set against each other. Then a long run of random strobes draws codes from a short list that is dense in special values. A behavioural model checks every cycle of both phases.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
    parameter int XLEN  = 32;
    parameter int EVT_W = 12;
    parameter int LVL_W = 4;

    localparam int BL_POS   = 28;
    localparam int RB_POS   = 29;
    localparam int MD_POS   = 30;
    localparam int FD_POS   = 15;
    localparam int IMASK_LO = 4;

    localparam logic [EVT_W-1:0] CODE_PWR    = 12'h000;
    localparam logic [EVT_W-1:0] CODE_MAN    = 12'h020;
    localparam logic [EVT_W-1:0] CODE_MULTI  = 12'h140;
    localparam logic [EVT_W-1:0] CODE_MISS_R = 12'h040;
    localparam logic [EVT_W-1:0] CODE_MISS_W = 12'h060;
    localparam logic [EVT_W-1:0] CODE_TRAP   = 12'h160;
    localparam logic [EVT_W-1:0] CODE_EXEMPT = 12'h1E0;

    localparam logic [XLEN-1:0] HARD_PC   = 32'hA000_0000;
    localparam logic [XLEN-1:0] OFS_GEN   = 32'h0000_0100;
    localparam logic [XLEN-1:0] OFS_MISS  = 32'h0000_0400;
    localparam logic [XLEN-1:0] OFS_IRQ   = 32'h0000_0600;
    localparam logic [XLEN-1:0] SR_RESET  = 32'h7000_00F0;

    typedef enum logic [1:0] {
        EV_NONE,
        EV_RESET,
        EV_EXC,
        EV_IRQ
    } ev_kind_e;
endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
    import exc_entry_pkg::*;
#(
    parameter int CW = EVT_W,
    parameter int LW = LVL_W
) (
    input  logic          exc_valid_i,
    input  logic [CW-1:0] exc_code_i,
    input  logic          irq_pend_i,
    input  logic [LW-1:0] irq_level_i,
    input  logic [LW-1:0] imask_i,
    input  logic          bl_i,
    input  logic          sleep_i,
    input  logic          dslot_i,
    output ev_kind_e      kind_o
);
    logic irq_blocked;

    always_comb begin
        irq_blocked = dslot_i || (bl_i && !sleep_i) || (irq_level_i <= imask_i);
        kind_o = EV_NONE;
        if (exc_valid_i) begin
            if (bl_i && (exc_code_i != CODE_EXEMPT)) begin
                kind_o = EV_RESET;
            end else begin
                kind_o = EV_EXC;
            end
        end else if (irq_pend_i && !irq_blocked) begin
            kind_o = EV_IRQ;
        end
    end
endmodule

// File: rtl/exc_target.sv
module exc_target
    import exc_entry_pkg::*;
#(
    parameter int XW = XLEN,
    parameter int CW = EVT_W
) (
    input  ev_kind_e      kind_i,
    input  logic [CW-1:0] code_i,
    input  logic [XW-1:0] vbr_i,
    input  logic [XW-1:0] pc_i,
    input  logic          dslot_i,
    output logic [XW-1:0] new_pc_o,
    output logic [XW-1:0] spc_o,
    output logic          hard_o
);
    localparam logic [XW-1:0] TWO = XW'(2);

    logic is_trap;
    logic is_miss;

    always_comb begin
        hard_o  = (kind_i == EV_EXC) &&
                  ((code_i == CODE_PWR) || (code_i == CODE_MAN) || (code_i == CODE_MULTI));
        is_miss = (code_i == CODE_MISS_R) || (code_i == CODE_MISS_W);
        is_trap = (kind_i == EV_EXC) && (code_i == CODE_TRAP);

        spc_o = pc_i;
        if (dslot_i) spc_o = spc_o - TWO;
        if (is_trap) spc_o = spc_o + TWO;

        if (kind_i == EV_IRQ) begin
            new_pc_o = vbr_i + OFS_IRQ;
        end else if (hard_o) begin
            new_pc_o = HARD_PC;
        end else if (is_miss) begin
            new_pc_o = vbr_i + OFS_MISS;
        end else begin
            new_pc_o = vbr_i + OFS_GEN;
        end
    end
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
    import exc_entry_pkg::*;
#(
    parameter int XW = XLEN,
    parameter int CW = EVT_W,
    parameter int LW = LVL_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          take_i,
    input  logic          exc_valid_i,
    input  logic [CW-1:0] exc_code_i,
    input  logic          irq_pend_i,
    input  logic [CW-1:0] irq_vec_i,
    input  logic [LW-1:0] irq_level_i,
    input  logic [XW-1:0] sr_i,
    input  logic [XW-1:0] pc_i,
    input  logic [XW-1:0] r15_i,
    input  logic [XW-1:0] vbr_i,
    input  logic          sleep_i,
    input  logic          dslot_i,
    output logic [XW-1:0] sr_o,
    output logic [XW-1:0] ssr_o,
    output logic [XW-1:0] spc_o,
    output logic [XW-1:0] sgr_o,
    output logic [CW-1:0] expevt_o,
    output logic [CW-1:0] intevt_o,
    output logic [XW-1:0] pc_o,
    output logic          rst_req_o,
    output logic          sleep_o,
    output logic          dslot_o
);
    typedef struct packed {
        logic [XW-1:0] sr;
        logic [XW-1:0] ssr;
        logic [XW-1:0] spc;
        logic [XW-1:0] sgr;
        logic [CW-1:0] expevt;
        logic [CW-1:0] intevt;
        logic [XW-1:0] pc;
        logic          rst_req;
        logic          sleep;
        logic          dslot;
    } state_t;

    state_t state_d, state_q;
    ev_kind_e      kind;
    logic [XW-1:0] tgt_pc;
    logic [XW-1:0] tgt_spc;
    logic          tgt_hard;
    logic [XW-1:0] sr_entry;

    exc_arbiter #(.CW(CW), .LW(LW)) u_arb (
        .exc_valid_i (exc_valid_i),
        .exc_code_i  (exc_code_i),
        .irq_pend_i  (irq_pend_i),
        .irq_level_i (irq_level_i),
        .imask_i     (sr_i[IMASK_LO +: LW]),
        .bl_i        (sr_i[BL_POS]),
        .sleep_i     (sleep_i),
        .dslot_i     (dslot_i),
        .kind_o      (kind)
    );

    exc_target #(.XW(XW), .CW(CW)) u_tgt (
        .kind_i   (kind),
        .code_i   (exc_code_i),
        .vbr_i    (vbr_i),
        .pc_i     (pc_i),
        .dslot_i  (dslot_i),
        .new_pc_o (tgt_pc),
        .spc_o    (tgt_spc),
        .hard_o   (tgt_hard)
    );

    always_comb begin
        state_d         = state_q;
        state_d.rst_req = 1'b0;
        sr_entry        = sr_i;
        sr_entry[BL_POS] = 1'b1;
        sr_entry[MD_POS] = 1'b1;
        sr_entry[RB_POS] = 1'b1;
        if (tgt_hard) begin
            sr_entry[FD_POS] = 1'b0;
            sr_entry[IMASK_LO +: LW] = '1;
        end
        if (take_i) begin
            case (kind)
                EV_RESET: state_d.rst_req = 1'b1;
                EV_EXC, EV_IRQ: begin
                    state_d.ssr   = sr_i;
                    state_d.spc   = tgt_spc;
                    state_d.sgr   = r15_i;
                    state_d.sr    = sr_entry;
                    state_d.pc    = tgt_pc;
                    state_d.sleep = 1'b0;
                    state_d.dslot = 1'b0;
                    if (kind == EV_EXC) state_d.expevt = exc_code_i;
                    else                state_d.intevt = irq_vec_i;
                end
                default: begin
                    state_d.sleep = sleep_i;
                    state_d.dslot = dslot_i;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= '0;
            state_q.sr <= SR_RESET;
        end else begin
            state_q <= state_d;
        end
    end

    assign sr_o      = state_q.sr;
    assign ssr_o     = state_q.ssr;
    assign spc_o     = state_q.spc;
    assign sgr_o     = state_q.sgr;
    assign expevt_o  = state_q.expevt;
    assign intevt_o  = state_q.intevt;
    assign pc_o      = state_q.pc;
    assign rst_req_o = state_q.rst_req;
    assign sleep_o   = state_q.sleep;
    assign dslot_o   = state_q.dslot;

    assert_exc_first_R1: assert property (@(posedge clk) disable iff (rst)
        (take_i && exc_valid_i) |-> (kind != EV_IRQ));

    assert_reset_only_R2: assert property (@(posedge clk) disable iff (rst)
        rst_req_o |-> ($stable(pc_o) && $stable(sr_o) && $stable(spc_o) && $stable(ssr_o)));

    assert_irq_level_R5: assert property (@(posedge clk) disable iff (rst)
        (take_i && kind == EV_IRQ) |-> (irq_level_i > sr_i[IMASK_LO +: LW]));

    assert_entry_bits_R6: assert property (@(posedge clk) disable iff (rst)
        (take_i && (kind == EV_EXC || kind == EV_IRQ)) |=>
        (sr_o[BL_POS] && sr_o[MD_POS] && sr_o[RB_POS] && !sleep_o && !dslot_o));

    assert_no_slot_irq_R11: assert property (@(posedge clk) disable iff (rst)
        (take_i && kind == EV_IRQ) |-> !dslot_i);

    assert_hold_R13: assert property (@(posedge clk) disable iff (rst)
        !take_i |=> ($stable(sr_o) && $stable(pc_o) && $stable(spc_o) && !rst_req_o));
endmodule

// File: tb/tb_exc_entry_seq.sv
module tb_exc_entry_seq;
    localparam int CLK_P = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic take_i = 0, exc_valid_i = 0, irq_pend_i = 0, sleep_i = 0, dslot_i = 0;
    logic [11:0] exc_code_i = 0, irq_vec_i = 0;
    logic [3:0]  irq_level_i = 0;
    logic [31:0] sr_i = 0, pc_i = 0, r15_i = 0, vbr_i = 0;
    logic [31:0] sr_o, ssr_o, spc_o, sgr_o, pc_o;
    logic [11:0] expevt_o, intevt_o;
    logic rst_req_o, sleep_o, dslot_o;

    int n_tests = 0;
    int n_fail  = 0;

    // reference state
    logic [31:0] e_sr, e_ssr, e_spc, e_sgr, e_pc;
    logic [11:0] e_exp, e_int;
    logic e_rq, e_sleep, e_dslot;

    always #(CLK_P/2) clk = ~clk;

    exc_entry_seq dut (
        .clk(clk), .rst(rst), .take_i(take_i), .exc_valid_i(exc_valid_i),
        .exc_code_i(exc_code_i), .irq_pend_i(irq_pend_i), .irq_vec_i(irq_vec_i),
        .irq_level_i(irq_level_i), .sr_i(sr_i), .pc_i(pc_i), .r15_i(r15_i),
        .vbr_i(vbr_i), .sleep_i(sleep_i), .dslot_i(dslot_i), .sr_o(sr_o),
        .ssr_o(ssr_o), .spc_o(spc_o), .sgr_o(sgr_o), .expevt_o(expevt_o),
        .intevt_o(intevt_o), .pc_o(pc_o), .rst_req_o(rst_req_o),
        .sleep_o(sleep_o), .dslot_o(dslot_o)
    );

    always @(posedge clk) begin
        bit go_exc, go_irq;
        if (rst) begin
            e_sr = 32'h7000_00F0; e_ssr = 0; e_spc = 0; e_sgr = 0; e_pc = 0;
            e_exp = 0; e_int = 0; e_rq = 0; e_sleep = 0; e_dslot = 0;
        end else begin
            e_rq = 0;
            if (take_i) begin
                go_exc = 0; go_irq = 0;
                if (exc_valid_i) begin
                    if (sr_i[28] && exc_code_i != 12'h1E0) e_rq = 1;
                    else go_exc = 1;
                end else if (irq_pend_i && !dslot_i && (!sr_i[28] || sleep_i)
                             && irq_level_i > sr_i[7:4]) begin
                    go_irq = 1;
                end
                if (go_exc || go_irq) begin
                    e_ssr = sr_i;
                    e_spc = pc_i;
                    if (dslot_i) e_spc = e_spc - 2;
                    if (go_exc && exc_code_i == 12'h160) e_spc = e_spc + 2;
                    e_sgr = r15_i;
                    e_sr = sr_i | 32'h7000_0000;
                    e_sleep = 0; e_dslot = 0;
                    if (go_exc) begin
                        e_exp = exc_code_i;
                        if (exc_code_i inside {12'h000, 12'h020, 12'h140}) begin
                            e_sr[15] = 0; e_sr[7:4] = 4'hF; e_pc = 32'hA000_0000;
                        end else if (exc_code_i inside {12'h040, 12'h060}) begin
                            e_pc = vbr_i + 32'h400;
                        end else begin
                            e_pc = vbr_i + 32'h100;
                        end
                    end else begin
                        e_int = irq_vec_i;
                        e_pc = vbr_i + 32'h600;
                    end
                end else if (!e_rq) begin
                    e_sleep = sleep_i; e_dslot = dslot_i;
                end
            end
        end
    end

    task automatic check(input string tag);
        logic [226:0] got, exp;
        got = {sr_o, ssr_o, spc_o, sgr_o, expevt_o, intevt_o, pc_o, rst_req_o, sleep_o, dslot_o};
        exp = {e_sr, e_ssr, e_spc, e_sgr, e_exp, e_int, e_pc, e_rq, e_sleep, e_dslot};
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // wait for one edge, then compare the resulting outputs
    task automatic run(input string tag);
        @(posedge clk);
        #(CLK_P/4);
        check(tag);
    endtask

    task automatic setup(input logic [31:0] sr, input logic ds, input logic sl);
        sr_i = sr; dslot_i = ds; sleep_i = sl;
        pc_i = 32'h0C00_1000 + 32'($urandom_range(0, 255)) * 2;
        r15_i = $urandom; vbr_i = 32'h8C00_0000;
        exc_valid_i = 0; irq_pend_i = 0; take_i = 1;
    endtask

    task automatic idle(input string tag);
        take_i = 0;
        run(tag);
    endtask

    initial begin
        #(CLK_P * 200000);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (2) @(posedge clk);
        #(CLK_P/4);
        rst = 0;
        check("R12");  // reset values visible

        // R1: both pending, exception wins
        setup(32'h0000_0010, 0, 0);
        exc_valid_i = 1; exc_code_i = 12'h180; irq_pend_i = 1; irq_vec_i = 12'h3A0; irq_level_i = 4'hF;
        run("R1"); idle("R13");

        // R2: block bit set -> reset request only
        setup(32'h1000_0000, 0, 0);
        exc_valid_i = 1; exc_code_i = 12'h0A0;
        run("R2"); idle("R2");

        // R3: exempt code under block bit
        setup(32'h5000_0030, 0, 0);
        exc_valid_i = 1; exc_code_i = 12'h1E0;
        run("R3"); idle("R13");

        // R4: blocked irq, awake -> refused; asleep -> taken
        setup(32'h1000_0000, 0, 0);
        irq_pend_i = 1; irq_vec_i = 12'h200; irq_level_i = 4'h9;
        run("R4");
        setup(32'h1000_0000, 0, 1);
        irq_pend_i = 1; irq_vec_i = 12'h220; irq_level_i = 4'h9;
        run("R4"); idle("R13");

        // R5: level equal to mask refused, higher taken
        setup(32'h0000_0070, 0, 0);
        irq_pend_i = 1; irq_vec_i = 12'h240; irq_level_i = 4'h7;
        run("R5");
        setup(32'h0000_0070, 0, 1);
        irq_pend_i = 1; irq_vec_i = 12'h260; irq_level_i = 4'h8;
        run("R5"); idle("R13");

        // R6: save fields
        setup(32'h0000_8123, 0, 0);
        exc_valid_i = 1; exc_code_i = 12'h0E0;
        run("R6");

        // R7: exception from delay slot
        setup(32'h0000_0000, 1, 0);
        exc_valid_i = 1; exc_code_i = 12'h180;
        run("R7");

        // R8: hard codes
        foreach (hard_codes[k]) begin
            setup(32'h0000_8000, 0, 0);
            exc_valid_i = 1; exc_code_i = hard_codes[k];
            run("R8");
        end

        // R9: miss offsets and general offset
        setup(0, 0, 0); exc_valid_i = 1; exc_code_i = 12'h040; run("R9");
        setup(0, 0, 0); exc_valid_i = 1; exc_code_i = 12'h060; run("R9");
        setup(0, 0, 0); exc_valid_i = 1; exc_code_i = 12'h100; run("R9");

        // R10: trap, plain and from delay slot
        setup(0, 0, 0); exc_valid_i = 1; exc_code_i = 12'h160; run("R10");
        setup(0, 1, 0); exc_valid_i = 1; exc_code_i = 12'h160; run("R10");

        // R11: irq in delay slot refused
        setup(0, 1, 1); irq_pend_i = 1; irq_vec_i = 12'h2C0; irq_level_i = 4'hF;
        run("R11");

        // R13: no strobe, busy inputs
        setup(0, 1, 1); take_i = 0; exc_valid_i = 1; exc_code_i = 12'h000;
        run("R13");
        setup(0, 0, 0); exc_valid_i = 0; irq_pend_i = 0; run("R13");

        // random phase
        for (int i = 0; i < 2000; i++) begin
            setup({1'b0, 3'($urandom), 12'($urandom), 16'($urandom)},
                  1'($urandom), 1'($urandom));
            take_i = 1'($urandom);
            exc_valid_i = ($urandom_range(0, 2) == 0);
            exc_code_i = rnd_codes[$urandom_range(0, 9)];
            irq_pend_i = 1'($urandom);
            irq_vec_i = 12'($urandom);
            irq_level_i = 4'($urandom);
            run("R1/R6");
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    logic [11:0] hard_codes [3] = '{12'h000, 12'h020, 12'h140};
    logic [11:0] rnd_codes [10] = '{12'h000, 12'h020, 12'h140, 12'h040, 12'h060,
                                    12'h160, 12'h1E0, 12'h0A0, 12'h180, 12'h100};
endmodule